// File: doc/BRIEF.md
# SM4 Round-Key Expansion Engine

This block expands a 128-bit SM4 cipher key into the thirty-two 32-bit round keys the cipher consumes. A one-cycle start pulse, sampled while the engine is idle, captures the key. From then on the engine works through one expansion round per clock and presents each new round key on its output together with its round index and a valid strobe. The last key comes with a one-cycle done pulse.

Inside, a four-word state register holds the running key material. Loading whitens the key with four fixed system words. Each round then mixes the three younger words with a round constant, passes the result through four S-box byte substitutions and a rotate-and-XOR mix, and XORs that with the oldest word. The result is both the round key and the new youngest state word. The round constants are not stored: they are computed from the round index. The block keeps no copy of the full key array. A consumer must capture each key in the cycle its strobe is high.

Top module: `sm4ks_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, busyOut, rkValidOut and doneOut are 0, and rkIdxOut and rkOut are 0.
- R2: A high startIn sampled while busyOut is 0 captures keyIn. At the next edge busyOut goes to 1, and rkValidOut stays 0 for that cycle.
- R3: After a start, exactly 32 round keys are produced in 32 consecutive cycles. rkValidOut is high in each of them, and rkIdxOut counts 0, 1, ..., 31 in order.
- R4: Before the first round, key word k (k = 0 for keyIn[127:96]) is XORed with A3B1BAC6, 56AA3350, 677D9197 and B27022DC respectively. In round i, let X be words 1, 2 and 3 XORed with constant i. Each byte of X is substituted through the SM4 S-box to give B. Round key i is word 0 XOR B XOR (B rotated left 13) XOR (B rotated left 23). The state then becomes {word1, word2, word3, round key i}.
- R5: Byte j of round constant i, with j = 0 the most significant byte, is ((4*i + j) * 7) mod 256. For the key 0123456789ABCDEFFEDCBA9876543210, round key 0 is F12186F9 and round key 31 is 9124A012.
- R6: doneOut is high for exactly one cycle. In that cycle rkIdxOut is 31, rkValidOut is 1 and busyOut is already 0.
- R7: A startIn pulse while busyOut is 1 is ignored. The running expansion continues with the original key, and no extra key appears.
- R8: A start given in the cycle doneOut is high is accepted, so a new expansion can follow the previous one with no idle cycle.
- R9: When neither an expansion nor its final key is in progress (busyOut and doneOut both 0), rkValidOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse; keyIn is captured when the engine is idle |
| keyIn | input | 128 | Cipher key, most significant word first |
| busyOut | output | 1 | Expansion in progress |
| rkValidOut | output | 1 | Round key on rkOut is valid this cycle |
| rkIdxOut | output | 5 | Index of the round key on rkOut |
| rkOut | output | 32 | Round key |
| doneOut | output | 1 | One-cycle pulse with the final round key |

## Verification
The bench builds the engine with its default ROUNDS of 32, the only count the cipher defines. With that count, every round constant is reached, including the rounds past the tenth where (4*i + j)*7 wraps modulo 256, and the index counter reaches its full 5-bit range and wraps. Random keys are compared key by key against an independent model of the expansion. Directed runs cover the published test key, a start pulse landing in the middle of a run, and a restart issued in the same cycle as done.

// File: rtl/sm4ks_pkg.sv
package sm4ks_pkg;

  localparam int WORD_W  = 32;
  localparam int NWORDS  = 4;
  localparam int KEY_W   = WORD_W * NWORDS;
  localparam int BYTES_W = WORD_W / 8;

  // Whitening words applied to the key before round 0, index 0 = top word
  localparam logic [WORD_W-1:0] WHITEN [NWORDS] = '{
    32'hA3B1BAC6, 32'h56AA3350, 32'h677D9197, 32'hB27022DC
  };

  typedef struct packed {
    logic load;   // capture key, clear round counter
    logic step;   // advance one expansion round
  } ksCtrl_t;

  // Round constant: byte j (0 = MSB) is (4*r + j) * 7 mod 256
  function automatic logic [WORD_W-1:0] roundConst(input int unsigned r);
    logic [WORD_W-1:0] acc;
    acc = '0;
    for (int j = 0; j < BYTES_W; j++) begin
      acc[WORD_W-8-8*j +: 8] = 8'(((4 * r + j) * 7) % 256);
    end
    return acc;
  endfunction

  // SM4 substitution box, eight entries packed per 64-bit row
  function automatic logic [7:0] sboxByte(input logic [7:0] x);
    logic [63:0] row;
    int          sh;
    row = '0;
    case (x[7:3])
      5'd0:  row = 64'hd690e9fecce13db7;
      5'd1:  row = 64'h16b614c228fb2c05;
      5'd2:  row = 64'h2b679a762abe04c3;
      5'd3:  row = 64'haa44132649860699;
      5'd4:  row = 64'h9c4250f491ef987a;
      5'd5:  row = 64'h33540b43edcfac62;
      5'd6:  row = 64'he4b31ca9c908e895;
      5'd7:  row = 64'h80df94fa758f3fa6;
      5'd8:  row = 64'h4707a7fcf37317ba;
      5'd9:  row = 64'h83593c19e6854fa8;
      5'd10: row = 64'h686b81b27164da8b;
      5'd11: row = 64'hf8eb0f4b70569d35;
      5'd12: row = 64'h1e240e5e6358d1a2;
      5'd13: row = 64'h25227c3b01217887;
      5'd14: row = 64'hd40046579fd32752;
      5'd15: row = 64'h4c3602e7a0c4c89e;
      5'd16: row = 64'heabf8ad240c738b5;
      5'd17: row = 64'ha3f7f2cef96115a1;
      5'd18: row = 64'he0ae5da49b341a55;
      5'd19: row = 64'had933230f58cb1e3;
      5'd20: row = 64'h1df6e22e8266ca60;
      5'd21: row = 64'hc02923ab0d534e6f;
      5'd22: row = 64'hd5db3745defd8e2f;
      5'd23: row = 64'h03ff6a726d6c5b51;
      5'd24: row = 64'h8d1baf92bbddbc7f;
      5'd25: row = 64'h11d95c411f105ad8;
      5'd26: row = 64'h0ac13188a5cd7bbd;
      5'd27: row = 64'h2d74d012b8e5b4b0;
      5'd28: row = 64'h8969974a0c96777e;
      5'd29: row = 64'h65b9f109c56ec684;
      5'd30: row = 64'h18f07dec3adc4d20;
      5'd31: row = 64'h79ee5f3ed7cb3948;
    endcase
    sh = 8 * (7 - int'(x[2:0]));
    return row[sh +: 8];
  endfunction

endpackage

// File: rtl/sm4ks_ctrl.sv
module sm4ks_ctrl
  import sm4ks_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  output ksCtrl_t          ctrl,
  output logic [IDX_W-1:0] roundIdx,
  output logic             busyOut,
  output logic             rkValidOut,
  output logic [IDX_W-1:0] rkIdxOut,
  output logic             doneOut
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);

  logic             busyQ;
  logic [IDX_W-1:0] cntQ;
  logic             atLast;

  assign atLast    = (cntQ == LAST_IDX);
  assign ctrl.load = startIn && !busyQ;
  assign ctrl.step = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      cntQ       <= '0;
      rkValidOut <= 1'b0;
      rkIdxOut   <= '0;
      doneOut    <= 1'b0;
    end else begin
      rkValidOut <= ctrl.step;
      doneOut    <= ctrl.step && atLast;
      if (ctrl.step) begin
        rkIdxOut <= cntQ;
      end
      if (ctrl.load) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (ctrl.step) begin
        cntQ <= cntQ + 1'b1;
        if (atLast) begin
          busyQ <= 1'b0;
        end
      end
    end
  end

  assign roundIdx = cntQ;
  assign busyOut  = busyQ;

endmodule

// File: rtl/sm4ks_datapath.sv
module sm4ks_datapath
  import sm4ks_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ksCtrl_t           ctrl,
  input  logic [IDX_W-1:0]  roundIdx,
  input  logic [KEY_W-1:0]  keyIn,
  output logic [WORD_W-1:0] rkOut
);

  localparam int ROT_A = 13;
  localparam int ROT_B = 23;

  logic [WORD_W-1:0] stateQ [NWORDS];
  logic [WORD_W-1:0] mixIn;
  logic [WORD_W-1:0] subWord;
  logic [WORD_W-1:0] mixed;
  logic [WORD_W-1:0] newKey;

  assign mixIn = stateQ[1] ^ stateQ[2] ^ stateQ[3] ^ roundConst(int'(roundIdx));

  for (genvar g = 0; g < BYTES_W; g++) begin : gSub
    assign subWord[8*g +: 8] = sboxByte(mixIn[8*g +: 8]);
  end

  assign mixed  = subWord
                ^ {subWord[WORD_W-1-ROT_A:0], subWord[WORD_W-1:WORD_W-ROT_A]}
                ^ {subWord[WORD_W-1-ROT_B:0], subWord[WORD_W-1:WORD_W-ROT_B]};
  assign newKey = stateQ[0] ^ mixed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NWORDS; k++) stateQ[k] <= '0;
      rkOut <= '0;
    end else if (ctrl.load) begin
      for (int k = 0; k < NWORDS; k++) begin
        stateQ[k] <= keyIn[KEY_W-WORD_W-WORD_W*k +: WORD_W] ^ WHITEN[k];
      end
    end else if (ctrl.step) begin
      for (int k = 0; k < NWORDS-1; k++) stateQ[k] <= stateQ[k+1];
      stateQ[NWORDS-1] <= newKey;
      rkOut            <= newKey;
    end
  end

endmodule

// File: rtl/sm4ks_top.sv
module sm4ks_top
  import sm4ks_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [KEY_W-1:0]  keyIn,
  output logic              busyOut,
  output logic              rkValidOut,
  output logic [IDX_W-1:0]  rkIdxOut,
  output logic [WORD_W-1:0] rkOut,
  output logic              doneOut
);

  ksCtrl_t          ctrl;
  logic [IDX_W-1:0] roundIdx;

  sm4ks_ctrl #(.ROUNDS(ROUNDS)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .ctrl(ctrl),
    .roundIdx(roundIdx), .busyOut(busyOut), .rkValidOut(rkValidOut),
    .rkIdxOut(rkIdxOut), .doneOut(doneOut)
  );

  sm4ks_datapath #(.IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .roundIdx(roundIdx),
    .keyIn(keyIn), .rkOut(rkOut)
  );

endmodule

// File: rtl/sm4ks_chk.sv
module sm4ks_chk #(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic             busyOut,
  input logic             rkValidOut,
  input logic [IDX_W-1:0] rkIdxOut,
  input logic             doneOut
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn && !busyOut |=> busyOut && !rkValidOut);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rkValidOut && (rkIdxOut != LAST_IDX) |=>
      rkValidOut && (rkIdxOut == $past(rkIdxOut) + 1'b1));

  // R6
  done_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> rkValidOut && (rkIdxOut == LAST_IDX) && !busyOut);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut && !doneOut |-> !rkValidOut);

endmodule

bind sm4ks_top sm4ks_chk #(.ROUNDS(ROUNDS)) uChk (.*);

// File: tb/sim_sm4ks_top.sv
module sim_sm4ks_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [127:0] keyIn = '0;
  logic         busyOut, rkValidOut, doneOut;
  logic [4:0]   rkIdxOut;
  logic [31:0]  rkOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expKeys [32];

  always #4 clk = ~clk;

  sm4ks_top u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .keyIn(keyIn),
    .busyOut(busyOut), .rkValidOut(rkValidOut), .rkIdxOut(rkIdxOut),
    .rkOut(rkOut), .doneOut(doneOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // Independent expansion model built from R4 and R5
  task automatic model(input logic [127:0] key);
    logic [31:0] k [4];
    logic [31:0] fk [4];
    logic [31:0] ck, t, b;
    fk[0] = 32'hA3B1BAC6; fk[1] = 32'h56AA3350;
    fk[2] = 32'h677D9197; fk[3] = 32'hB27022DC;
    for (int w = 0; w < 4; w++) k[w] = key[127-32*w -: 32] ^ fk[w];
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'(((4*i + j) * 7) % 256);
      t = k[1] ^ k[2] ^ k[3] ^ ck;
      for (int j = 0; j < 4; j++) b[8*j +: 8] = sm4ks_pkg::sboxByte(t[8*j +: 8]);
      expKeys[i] = k[0] ^ b ^ rotl(b, 13) ^ rotl(b, 23);
      k[0] = k[1]; k[1] = k[2]; k[2] = k[3]; k[3] = expKeys[i];
    end
  endtask

  // Drive a start from idle and check the load cycle
  task automatic startKey(input logic [127:0] key);
    @(negedge clk);
    startIn = 1'b1; keyIn = key;
    @(negedge clk);
    startIn = 1'b0; keyIn = {$urandom, $urandom, $urandom, $urandom};
    chk(busyOut === 1'b1, "R2", "busy after start", 32'(busyOut), 32'd1);
    chk(rkValidOut === 1'b0, "R2", "valid in load cycle", 32'(rkValidOut), 32'd0);
  endtask

  // Collect 32 keys; optionally poke a start mid-run or chain a new start at done
  task automatic collect(input logic [127:0] key, input int pokeAt,
                         input logic [127:0] pokeKey, input bit chain,
                         input logic [127:0] chainKey);
    model(key);
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      chk(rkValidOut === 1'b1, "R3", "valid", 32'(rkValidOut), 32'd1);
      chk(rkIdxOut === 5'(r), "R3", "index", 32'(rkIdxOut), 32'(r));
      chk(rkOut === expKeys[r], (pokeAt >= 0) ? "R7" : "R4", "round key", rkOut, expKeys[r]);
      chk(doneOut === (r == 31), "R6", "done", 32'(doneOut), 32'(r == 31));
      chk(busyOut === (r != 31), "R6", "busy", 32'(busyOut), 32'(r != 31));
      if (r == pokeAt) begin
        startIn = 1'b1; keyIn = pokeKey;
      end else if (chain && r == 31) begin
        startIn = 1'b1; keyIn = chainKey;
      end else begin
        startIn = 1'b0;
      end
    end
  endtask

  initial begin
    logic [127:0] rk;
    void'($urandom(32'd20240517));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({busyOut, rkValidOut, doneOut} === 3'b000, "R1", "flags in reset",
        32'({busyOut, rkValidOut, doneOut}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rkOut === 32'd0 && rkIdxOut === 5'd0, "R1", "outputs after reset", rkOut, 32'd0);
    chk(busyOut === 1'b0, "R1", "busy after reset", 32'(busyOut), 32'd0);

    // R5: published test key
    startKey(128'h0123456789ABCDEFFEDCBA9876543210);
    collect(128'h0123456789ABCDEFFEDCBA9876543210, -1, '0, 1'b0, '0);
    chk(expKeys[0] === 32'hF12186F9, "R5", "model key 0", expKeys[0], 32'hF12186F9);
    chk(expKeys[31] === 32'h9124A012, "R5", "model key 31", expKeys[31], 32'h9124A012);
    @(negedge clk);
    startIn = 1'b0;
    chk(rkValidOut === 1'b0, "R9", "valid after run", 32'(rkValidOut), 32'd0);
    chk(doneOut === 1'b0, "R6", "done single cycle", 32'(doneOut), 32'd0);

    // R4: random keys
    for (int n = 0; n < 6; n++) begin
      rk = {$urandom, $urandom, $urandom, $urandom};
      startKey(rk);
      collect(rk, -1, '0, 1'b0, '0);
      @(negedge clk);
      startIn = 1'b0;
    end

    // R4: corner keys all-zero and all-one
    startKey('0);
    collect('0, -1, '0, 1'b0, '0);
    @(negedge clk); startIn = 1'b0;
    startKey('1);
    collect('1, -1, '0, 1'b0, '0);
    @(negedge clk); startIn = 1'b0;

    // R7: start pulses while busy are ignored
    rk = {$urandom, $urandom, $urandom, $urandom};
    startKey(rk);
    collect(rk, 0, ~rk, 1'b0, '0);
    @(negedge clk); startIn = 1'b0;
    chk(rkValidOut === 1'b0 && busyOut === 1'b0, "R7", "no extra run",
        32'({busyOut, rkValidOut}), 32'd0);
    startKey(rk);
    collect(rk, 17, 128'h0123456789ABCDEFFEDCBA9876543210, 1'b0, '0);
    @(negedge clk); startIn = 1'b0;
    chk(busyOut === 1'b0, "R7", "idle after poked run", 32'(busyOut), 32'd0);

    // R8: restart in the done cycle
    rk = {$urandom, $urandom, $urandom, $urandom};
    startKey(rk);
    collect(rk, -1, '0, 1'b1, 128'h0123456789ABCDEFFEDCBA9876543210);
    @(negedge clk);
    startIn = 1'b0;
    chk(busyOut === 1'b1, "R8", "busy after chained start", 32'(busyOut), 32'd1);
    chk(rkValidOut === 1'b0, "R8", "load cycle valid", 32'(rkValidOut), 32'd0);
    collect(128'h0123456789ABCDEFFEDCBA9876543210, -1, '0, 1'b0, '0);
    chk(rkOut === 32'h9124A012, "R8", "chained last key", rkOut, 32'h9124A012);
    @(negedge clk); startIn = 1'b0;
    chk(rkValidOut === 1'b0, "R9", "quiet at end", 32'(rkValidOut), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule